// File: doc/BRIEF.md
# Loadable Down Counter with Zero Flag

This block is a down counter with a parameterised width (eight bits by default) that serves as a duration timer. A load strobe places a start value into the count register. On each following clock edge without a load, the count drops by one. When the count reaches zero it stays there and the done flag goes high. A new start value can be loaded at any moment, including in the middle of a countdown and while the counter sits at zero.

The next-count path has three parts. A borrow-chain subtractor produces count minus one. A selector then chooses among the load value, the decremented value and the held value. A zero detector reads the register and drives the done output directly, so done follows the registered count with no extra register stage.

Top module: `downcnt_timer`

## Requirements
- R1: While `rst` is high at a rising edge, the count becomes 0 on that edge, and `done` reads 1 afterwards.
- R2: When `load` is high at a rising edge and `rst` is low, `count` equals `load_val` after that edge, whatever the previous count was.
- R3: When `load` and `rst` are low and the count is non-zero at a rising edge, the count after the edge is the previous count minus one.
- R4: When `load` and `rst` are low and the count is zero at a rising edge, the count stays 0. It never wraps to the all-ones value.
- R5: `done` is 1 exactly in the cycles where `count` is 0, and it changes in the same cycle as the count.
- R6: A load in the middle of a countdown restarts the countdown from the new value. Load takes priority over decrement.
- R7: Loading the value 0 gives count 0 and `done` high on the next cycle, with no decrement and no wrap.
- R8: Reset takes priority over load. If `rst` and `load` are both high at an edge, the count becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Load strobe; captures `load_val` on the next edge |
| load_val | input | WIDTH | Start value for the countdown |
| count | output | WIDTH | Current registered count |
| done | output | 1 | High when the count is zero |

## Verification
Every possible start value from 0 to 255 is loaded. Each one is followed cycle by cycle down to zero and then for two held cycles. This exposes borrow-chain errors at every bit boundary and any wrap below zero. It also confirms that `done` rises in the cycle the count first reaches zero, and not one cycle early or late.

Further cases check priority. A reload mid-countdown, a reload of zero mid-countdown and a reload from the held-zero state separate "load wins" from "decrement wins". Asserting reset and load together shows which of those two has priority.

// File: rtl/downcnt_pkg.sv
package downcnt_pkg;
  typedef enum logic [1:0] {
    NXT_HOLD = 2'd0,
    NXT_DEC  = 2'd1,
    NXT_LOAD = 2'd2
  } nxt_sel_e;
endpackage

// File: rtl/downcnt_zero_det.sv
module downcnt_zero_det #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] value,
  output logic             is_zero
);
  assign is_zero = ~|value;
endmodule

// File: rtl/downcnt_next.sv
module downcnt_next
  import downcnt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             cur_zero,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  output nxt_sel_e         sel,
  output logic [WIDTH-1:0] nxt
);
  logic [WIDTH:0]   borrow;
  logic [WIDTH-1:0] dec;

  // Ripple-borrow subtract of one: borrow-in of bit 0 is the constant one.
  assign borrow[0] = 1'b1;
  for (genvar i = 0; i < WIDTH; i++) begin : g_sub
    assign dec[i]      = cur[i] ^ borrow[i];
    assign borrow[i+1] = ~cur[i] & borrow[i];
  end

  always_comb begin
    if (load)          sel = NXT_LOAD;
    else if (cur_zero) sel = NXT_HOLD;
    else               sel = NXT_DEC;
  end

  always_comb begin
    unique case (sel)
      NXT_LOAD: nxt = load_val;
      NXT_DEC:  nxt = dec;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/downcnt_reg.sv
module downcnt_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/downcnt_timer.sv
module downcnt_timer
  import downcnt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] count,
  output logic             done
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             zero;
  nxt_sel_e         sel;

  downcnt_zero_det #(.WIDTH(WIDTH)) zero_i (
    .value   (cnt_q),
    .is_zero (zero)
  );

  downcnt_next #(.WIDTH(WIDTH)) next_i (
    .cur      (cnt_q),
    .cur_zero (zero),
    .load     (load),
    .load_val (load_val),
    .sel      (sel),
    .nxt      (cnt_d)
  );

  downcnt_reg #(.WIDTH(WIDTH)) reg_i (
    .clk (clk),
    .rst (rst),
    .d   (cnt_d),
    .q   (cnt_q)
  );

  assign count = cnt_q;
  assign done  = zero;

  p_load_capture_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> (count == $past(load_val)));

  p_decrement_r3: assert property (@(posedge clk) disable iff (rst)
    (!load && count != '0) |=> (count == $past(count) - ONE));

  p_hold_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (!load && count == '0) |=> (count == '0) && done);

  p_zero_load_done_r7: assert property (@(posedge clk) disable iff (rst)
    (load && load_val == '0) |=> done);

  p_sel_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    load |-> (sel == NXT_LOAD));
endmodule

// File: tb/downcnt_timer_tb.sv
module downcnt_timer_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load = 1'b0;
  logic [W-1:0] load_val = '0;
  logic [W-1:0] count;
  logic         done;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  downcnt_timer #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val),
    .count(count), .done(done)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic chk_state(input string req, input int exp);
    chk(req, count, exp);
    chk({req, "/R5 done"}, done, (exp == 0) ? 1 : 0);
  endtask

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int exp;
    step(); step();
    chk_state("R1 reset", 0);
    // R8: reset and load together
    load = 1'b1; load_val = 8'd55;
    step();
    chk_state("R8 reset over load", 0);
    rst = 1'b0; load = 1'b0;
    step();
    chk_state("R4 hold after reset", 0);

    // Exhaustive sweep of start values (R2, R3, R4, R5, R7)
    for (int v = 0; v < 256; v++) begin
      load = 1'b1; load_val = W'(v);
      step();
      load = 1'b0;
      chk_state((v == 0) ? "R7 load zero" : "R2 load", v);
      exp = v;
      for (int k = 0; k < v + 2; k++) begin
        step();
        exp = (exp > 0) ? exp - 1 : 0;
        chk_state((exp == 0) ? "R4 hold/R3 last" : "R3 decrement", exp);
      end
    end

    // R6: reload mid-countdown
    load = 1'b1; load_val = 8'd200;
    step();
    load = 1'b0;
    for (int k = 0; k < 10; k++) step();
    chk_state("R3 after 10", 190);
    load = 1'b1; load_val = 8'd7;
    step();
    load = 1'b0;
    chk_state("R6 reload mid", 7);
    step();
    chk_state("R6 continue", 6);
    // R7: load zero mid-countdown
    load = 1'b1; load_val = 8'd0;
    step();
    load = 1'b0;
    chk_state("R7 zero mid", 0);
    step();
    chk_state("R4 no wrap", 0);
    // R2: reload from held zero, load held for two cycles
    load = 1'b1; load_val = 8'd3;
    step();
    chk_state("R2 from zero", 3);
    step();
    chk_state("R6 held load wins", 3);
    load = 1'b0;
    step();
    chk_state("R3 after held load", 2);
    // R1: reset mid-count
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk_state("R1 reset mid", 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule